// File: doc/BRIEF.md
# Filter Gate Request and Status Controller

This block decides when each of up to four filter ports may take new transactions. Software writes the gate state it wants into one 32-bit control word. It then reads the same word until the reported state matches the requested one. The lower half of the word holds the requests, one bit per filter, with bit 0 for filter 0. The upper half holds the gate state each filter currently reports, in the same bit order, and software cannot write it.

The reported state does not follow a request at once. Opening a gate takes a fixed two-cycle synchronisation delay. Closing a gate waits until that filter's count of outstanding transactions reaches zero. New transactions are refused from the cycle the close request is registered. If a request changes again before the earlier change has finished, the filter acts on the latest request. Each filter runs its own state machine, so filters do not affect one another.

The number of implemented filters is a parameter from 1 to 4. Request bits above that number are dropped, and the status bits for those positions read as zero.

Top module: `filter_gate_ctrl`

## Requirements
- R1: After reset, every request bit, every status bit and every admit output is 0, so the whole control word reads 0x0000_0000.
- R2: A write stores bits [NUM_FILTERS-1:0] of the write data as the requests. From the cycle after the write, they read back in bits [NUM_FILTERS-1:0] of the control word.
- R3: Writes to bits [31:16] have no effect. Bits [16+i] of a read always show the current status of filter i.
- R4: Request bits at positions NUM_FILTERS and above are ignored. Those bits, and the status bits at 16+NUM_FILTERS and above, always read 0, and no gate opens for them.
- R5: If the request of a closed filter is 1 and stays 1, its status bit becomes 1 exactly two cycles after the request first reads back as 1.
- R6: When the request of an open filter goes to 0 while that filter's outstanding count is not zero, the status stays 1. It falls to 0 in the cycle after the count is first seen as zero.
- R7: When the request of an open filter goes to 0 while its outstanding count is zero, the status falls to 0 one cycle after the request reads back as 0.
- R8: The admit output of filter i is 1 only while both its request and its status are 1. It drops in the same cycle the request reads back as 0, even while the filter is still draining.
- R9: If the request returns to 1 while a filter is still draining, the status never falls, and admit comes back as soon as the request reads 1.
- R10: If the request returns to 0 during the opening delay, the status never rises and the filter goes back to closed.
- R11: Each filter changes state only because of its own request bit and its own outstanding count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr_en | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 32 | Write data for the control word; only the request half is used |
| ctl_rdata | output | 32 | Control word readback: {status in [31:16], requests in [15:0]} |
| filt_pending | input | NUM_FILTERS*CNT_W | Outstanding-transaction count for each filter, filter i in slice [i*CNT_W +: CNT_W] |
| filt_admit | output | NUM_FILTERS | Per-filter permission to accept new transactions |

## Verification
The bench checks the exact cycle in which each status bit changes. A design that adds or drops a stage in the open delay or in the idle close is caught at the single cycle where the status word is sampled. A close is tested while transactions are still outstanding: a design that closes without waiting for the drain drops the status early. A design that holds admit high until the drain ends is caught when admit fails to fall with the request. Reversals are tested in both directions, a reopen during a drain and a close during the opening delay: a design that finishes the earlier transition first shows a status glitch. The bench builds the block with three filters and writes 1 to bit 3 and to the upper half, so a design that stores those bits reads back a nonzero value where zero is expected.

// File: rtl/gk_pkg.sv
package gk_pkg;

  localparam int unsigned HALF_W = 16;

  typedef enum logic [1:0] {
    GS_CLOSED  = 2'd0,
    GS_OPENING = 2'd1,
    GS_OPEN    = 2'd2,
    GS_DRAIN   = 2'd3
  } gate_st_e;

  // Control word layout: status half on top, request half at the bottom.
  function automatic logic [2*HALF_W-1:0] pack_word(input logic [HALF_W-1:0] req,
                                                    input logic [HALF_W-1:0] st);
    return {st, req};
  endfunction

  // A gate reports open while it is open or still draining.
  function automatic logic reports_open(input gate_st_e s);
    return (s == GS_OPEN) || (s == GS_DRAIN);
  endfunction

endpackage

// File: rtl/gk_req_reg.sv
module gk_req_reg #(
  parameter int unsigned NUM_FILTERS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [31:0]            wdata,
  input  logic [NUM_FILTERS-1:0] status,
  output logic [NUM_FILTERS-1:0] req,
  output logic [31:0]            rdata
);
  import gk_pkg::*;

  logic [NUM_FILTERS-1:0] req_q;
  logic unused_wbits;

  // Only the implemented request bits are stored.
  assign unused_wbits = ^wdata[31:NUM_FILTERS];

  always_ff @(posedge clk) begin
    if (!rst_n)     req_q <= '0;
    else if (wr_en) req_q <= wdata[NUM_FILTERS-1:0];
  end

  assign req   = req_q;
  assign rdata = pack_word(HALF_W'(req_q), HALF_W'(status));

  // R2
  wr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> req == $past(wdata[NUM_FILTERS-1:0]));

  // R4
  always_comb begin
    if (rst_n) begin
      rd_unimpl_zero_chk: assert (rdata[HALF_W-1:NUM_FILTERS] == '0 &&
                                  rdata[2*HALF_W-1:HALF_W+NUM_FILTERS] == '0);
    end
  end

endmodule

// File: rtl/gk_filter_fsm.sv
module gk_filter_fsm #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned OPEN_DLY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [CNT_W-1:0] pending,
  output logic             status,
  output logic             admit
);
  import gk_pkg::*;

  localparam int unsigned DW = $clog2(OPEN_DLY + 1);

  gate_st_e        st_q, st_d;
  logic [DW-1:0]   dly_q, dly_d;

  // Named events for the checks below.
  logic idle, open_done, drain_done;
  assign idle       = (pending == '0);
  assign open_done  = (st_q == GS_OPENING) && req && (dly_q == DW'(OPEN_DLY - 1));
  assign drain_done = !req && idle && reports_open(st_q);

  always_comb begin
    st_d  = st_q;
    dly_d = dly_q;
    unique case (st_q)
      GS_CLOSED: if (req) begin
        st_d  = GS_OPENING;
        dly_d = DW'(1);
      end
      GS_OPENING: begin
        if (!req)          st_d = GS_CLOSED;
        else if (open_done) st_d = GS_OPEN;
        else               dly_d = dly_q + DW'(1);
      end
      GS_OPEN: if (!req) st_d = idle ? GS_CLOSED : GS_DRAIN;
      GS_DRAIN: begin
        if (req)       st_d = GS_OPEN;
        else if (idle) st_d = GS_CLOSED;
      end
      default: st_d = GS_CLOSED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= GS_CLOSED;
      dly_q <= '0;
    end else begin
      st_q  <= st_d;
      dly_q <= dly_d;
    end
  end

  assign status = reports_open(st_q);
  assign admit  = status && req;

  // R5 R10
  open_after_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status) |-> $past(req) && $past(st_q) == GS_OPENING);

  // R6 R7
  close_when_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status) |-> !$past(req) && $past(pending) == '0);

  // R8
  admit_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |-> !admit);

  // R9
  reopen_keeps_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == GS_DRAIN && req) |=> status);

endmodule

// File: rtl/filter_gate_ctrl.sv
module filter_gate_ctrl #(
  parameter int unsigned NUM_FILTERS = 4,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned OPEN_DLY    = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ctl_wr_en,
  input  logic [31:0]                  ctl_wdata,
  output logic [31:0]                  ctl_rdata,
  input  logic [NUM_FILTERS*CNT_W-1:0] filt_pending,
  output logic [NUM_FILTERS-1:0]       filt_admit
);

  logic [NUM_FILTERS-1:0] req_vec;
  logic [NUM_FILTERS-1:0] status_vec;

  gk_req_reg #(.NUM_FILTERS(NUM_FILTERS)) u_req (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ctl_wr_en),
    .wdata  (ctl_wdata),
    .status (status_vec),
    .req    (req_vec),
    .rdata  (ctl_rdata)
  );

  for (genvar i = 0; i < NUM_FILTERS; i++) begin : g_filt
    gk_filter_fsm #(.CNT_W(CNT_W), .OPEN_DLY(OPEN_DLY)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req_vec[i]),
      .pending (filt_pending[i*CNT_W +: CNT_W]),
      .status  (status_vec[i]),
      .admit   (filt_admit[i])
    );
  end

  // R1
  reset_closed_chk: assert property (@(posedge clk)
    !rst_n |=> status_vec == '0 && filt_admit == '0);

endmodule

// File: tb/filter_gate_ctrl_bench.sv
module filter_gate_ctrl_bench;
  localparam int NF = 3;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctl_wr_en = 1'b0;
  logic [31:0]   ctl_wdata = '0;
  logic [31:0]   ctl_rdata;
  logic [NF*CW-1:0] filt_pending = '0;
  logic [NF-1:0] filt_admit;

  filter_gate_ctrl #(.NUM_FILTERS(NF), .CNT_W(CW), .OPEN_DLY(2)) u_filter_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .filt_pending(filt_pending), .filt_admit(filt_admit)
  );

  always #5 clk = ~clk;

  typedef struct {
    int          cyc;
    logic [31:0] word;
    logic [NF-1:0] adm;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare expectations whose cycle has arrived.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (ctl_rdata !== e.word || filt_admit !== e.adm) begin
        n_fail++;
        $display("FAIL %s cyc %0d: word %h admit %b, expected word %h admit %b",
                 e.tag, cyc, ctl_rdata, filt_admit, e.word, e.adm);
      end
    end
  end

  task automatic expect_at(input int dc, input logic [31:0] w,
                           input logic [NF-1:0] a, input string tag);
    exp_t e;
    e.cyc = cyc + dc; e.word = w; e.adm = a; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    ctl_wr_en = 1'b1; ctl_wdata = d;
    tick(1);
    ctl_wr_en = 1'b0; ctl_wdata = '0;
  endtask

  task automatic drain_sb;
    while (sb.size() > 0) tick(1);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    expect_at(0, 32'h0, 3'b000, "R1");
    drain_sb();

    // R2 R3 R5: open filter 0, with garbage in upper half
    expect_at(1, 32'h0000_0001, 3'b000, "R2_R3");
    expect_at(2, 32'h0000_0001, 3'b000, "R5_not_yet");
    expect_at(3, 32'h0001_0001, 3'b001, "R5");
    wr(32'hFFFF_0001);
    drain_sb();

    // R4 R7 R8 R11: close idle filter 0, open 1 and 2, bit 3 unimplemented
    expect_at(1, 32'h0001_0006, 3'b000, "R4_R8");
    expect_at(2, 32'h0000_0006, 3'b000, "R7");
    expect_at(3, 32'h0006_0006, 3'b110, "R5_R11");
    wr(32'h0000_000E);
    drain_sb();

    // R6 R8: close filter 1 with 3 outstanding
    filt_pending = {4'd0, 4'd3, 4'd0};
    expect_at(1, 32'h0006_0004, 3'b100, "R8");
    expect_at(4, 32'h0006_0004, 3'b100, "R6_hold");
    wr(32'h0000_0004);
    tick(3);
    filt_pending = '0;
    expect_at(1, 32'h0004_0004, 3'b100, "R6");
    drain_sb();

    // R9: reopen filter 2 while draining
    filt_pending = {4'd5, 4'd0, 4'd0};
    expect_at(1, 32'h0004_0000, 3'b000, "R9_closing");
    expect_at(2, 32'h0004_0000, 3'b000, "R9_draining");
    expect_at(3, 32'h0004_0004, 3'b100, "R9_readmit");
    expect_at(5, 32'h0004_0004, 3'b100, "R9_stays");
    wr(32'h0000_0000);
    tick(1);
    wr(32'h0000_0004);
    drain_sb();
    filt_pending = '0;

    // R10: open filter 0 then cancel during the opening delay
    expect_at(1, 32'h0004_0005, 3'b100, "R10_req");
    expect_at(2, 32'h0004_0004, 3'b100, "R10_cancel");
    expect_at(3, 32'h0004_0004, 3'b100, "R10");
    expect_at(4, 32'h0004_0004, 3'b100, "R10_closed");
    wr(32'h0000_0005);
    wr(32'h0000_0004);
    drain_sb();

    // R7: close everything idle
    expect_at(1, 32'h0004_0000, 3'b000, "R7_req");
    expect_at(2, 32'h0000_0000, 3'b000, "R7_all");
    wr(32'h0000_0000);
    drain_sb();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule